// File: doc/BRIEF.md
# I2C Command-Word Sequencer

This block turns a queue of 10-bit command words into byte-level operations for a separate I2C bit engine. Software, or an upstream agent, pushes words into a 16-entry transmit queue. Each word carries one byte in bits 7:0 and two flag bits. Bit 8 means "open a transfer here". Bit 9 means "close the transfer afterwards". The sequencer pops the words, asks the engine for start, repeated-start, byte-write, byte-read and stop operations one at a time, and stores received bytes in a 16-entry receive queue.

A write is a start-flagged address word followed by data words, with the stop flag on the last word that is written. A read is a start-flagged address word with bit 0 set, followed by one length word. The low byte of the length word is the number of bytes to fetch. The master acknowledges every byte except the last. If the target refuses a byte, the rest of that transfer is dropped from the queue and the bus is released.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A word with bit 8 set opens a transfer. The sequencer requests a start (op 0), or a repeated start (op 1) when the bus is already owned. It then writes bits 7:0 as the address byte. If that address has bit 0 clear and bit 9 is set, a stop follows once the address is acknowledged.
- R2: A word with bit 8 clear, popped while the bus is owned, is written as a data byte (op 2). If the word has bit 9 set and the byte is acknowledged, a stop (op 4) follows; otherwise the bus stays owned.
- R3: After an acknowledged address with bit 0 set, the next word's bits 7:0 give a byte count N. The sequencer issues N reads (op 3) with master-NACK 0 on all of them except the last, which carries 1. It then stops if that word has bit 9 set.
- R4: A read count of zero produces no read operation, only the stop (or the retained bus if bit 9 is clear).
- R5: A NACK on any byte write raises tx_err for exactly one cycle. Queued words are discarded up to, but not including, the next word with bit 8 set, and a stop is issued.
- R6: A word with bit 8 clear that is popped while the bus is free is discarded with no engine operation.
- R7: bus_busy rises when a start completes and falls when a stop completes.
- R8: The transmit queue holds 16 words. tx_empty, tx_full and tx_half (occupancy at most 8) reflect its occupancy. A push while the queue is full is ignored.
- R9: The receive queue holds 16 bytes in arrival order and reports rx_empty and rx_full. No read is issued while it is full.
- R10: eng_req is a one-cycle request, and no new request is issued until eng_done answers the previous one. Op codes: 0 start, 1 repeated start, 2 write, 3 read, 4 stop.
- R11: After reset both queues are empty, the bus is free and no request or error is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Push tx_word into the transmit queue |
| tx_word | input | 10 | Command word: bit 9 stop, bit 8 start, bits 7:0 byte |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| eng_req | output | 1 | One-cycle operation request to the bit engine |
| eng_op | output | 3 | Operation code of the request |
| eng_wdata | output | 8 | Byte to write |
| eng_mnack | output | 1 | Master answers NACK on this read byte |
| eng_done | input | 1 | Engine completion pulse |
| eng_nack | input | 1 | Target NACK on a write, valid with eng_done |
| eng_rdata | input | 8 | Read byte, valid with eng_done |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_half | output | 1 | Transmit queue at most half full |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| bus_busy | output | 1 | Bus owned by this master |
| tx_err | output | 1 | Write NACK event pulse |

## Verification
A corrupted sequencer state shows up at the engine port within one operation. The wrong op code appears on the next eng_req, or a stop or repeated start goes missing in the logged stream. A wrong read counter shows in the number of read requests and in which read carries the master NACK, both visible as soon as the transfer ends. Queue pointer or occupancy faults show as out-of-order bytes at rx_data, as a dropped or extra word once the queue fills, or as a stalled read that never resumes after a pop.

// File: rtl/i2c_cmd_seq_pkg.sv
package i2c_cmd_seq_pkg;
  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_WRITE  = 3'd2,
    OP_READ   = 3'd3,
    OP_STOP   = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_OWNED, S_START_W, S_ADDR_W, S_CNT,
    S_RD_ISSUE, S_RD_W, S_DATA_W, S_FLUSH, S_STOP_W
  } seq_state_e;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [AW:0]   level
);
  localparam logic [AW:0] FULL_L = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign do_push = push && (level != FULL_L);
  assign do_pop  = pop && (level != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import i2c_cmd_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = BYTE_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] head,
  input  logic              tx_empty,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic              eng_req,
  output logic [2:0]        eng_op,
  output logic [BYTE_W-1:0] eng_wdata,
  output logic              eng_mnack,
  input  logic              eng_done,
  input  logic              eng_nack,
  output logic              bus_busy,
  output logic              tx_err
);
  localparam int START_BIT = BYTE_W;
  localparam int STOP_BIT  = BYTE_W + 1;
  localparam logic [BYTE_W-1:0] ONE = BYTE_W'(1);

  seq_state_e        state;
  logic [BYTE_W-1:0] addr_q, cnt_q;
  logic              stop_pend;
  logic              has;

  assign has = !tx_empty;

  always_comb begin
    tx_pop = 1'b0;
    case (state)
      S_IDLE, S_OWNED, S_CNT: tx_pop = has;
      S_FLUSH:                tx_pop = has && !head[START_BIT];
      default:                tx_pop = 1'b0;
    endcase
  end

  assign rx_push = (state == S_RD_W) && eng_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      eng_req   <= 1'b0;
      eng_op    <= OP_STOP;
      eng_wdata <= '0;
      eng_mnack <= 1'b0;
      bus_busy  <= 1'b0;
      tx_err    <= 1'b0;
      addr_q    <= '0;
      cnt_q     <= '0;
      stop_pend <= 1'b0;
    end else begin
      eng_req <= 1'b0;
      tx_err  <= 1'b0;
      case (state)
        S_IDLE: if (has && head[START_BIT]) begin
          eng_req   <= 1'b1;
          eng_op    <= OP_START;
          addr_q    <= head[BYTE_W-1:0];
          stop_pend <= head[STOP_BIT];
          state     <= S_START_W;
        end
        S_OWNED: if (has) begin
          eng_req   <= 1'b1;
          stop_pend <= head[STOP_BIT];
          if (head[START_BIT]) begin
            eng_op <= OP_RSTART;
            addr_q <= head[BYTE_W-1:0];
            state  <= S_START_W;
          end else begin
            eng_op    <= OP_WRITE;
            eng_wdata <= head[BYTE_W-1:0];
            state     <= S_DATA_W;
          end
        end
        S_START_W: if (eng_done) begin
          bus_busy  <= 1'b1;
          eng_req   <= 1'b1;
          eng_op    <= OP_WRITE;
          eng_wdata <= addr_q;
          state     <= S_ADDR_W;
        end
        S_ADDR_W: if (eng_done) begin
          if (eng_nack) begin
            tx_err <= 1'b1;
            state  <= S_FLUSH;
          end else if (addr_q[0]) begin
            state <= S_CNT;
          end else if (stop_pend) begin
            eng_req <= 1'b1;
            eng_op  <= OP_STOP;
            state   <= S_STOP_W;
          end else begin
            state <= S_OWNED;
          end
        end
        S_CNT: if (has) begin
          cnt_q     <= head[BYTE_W-1:0];
          stop_pend <= head[STOP_BIT];
          if (head[BYTE_W-1:0] != '0) begin
            state <= S_RD_ISSUE;
          end else if (head[STOP_BIT]) begin
            eng_req <= 1'b1;
            eng_op  <= OP_STOP;
            state   <= S_STOP_W;
          end else begin
            state <= S_OWNED;
          end
        end
        S_RD_ISSUE: if (!rx_full) begin
          eng_req   <= 1'b1;
          eng_op    <= OP_READ;
          eng_mnack <= (cnt_q == ONE);
          state     <= S_RD_W;
        end
        S_RD_W: if (eng_done) begin
          cnt_q <= cnt_q - ONE;
          if (cnt_q != ONE) begin
            state <= S_RD_ISSUE;
          end else if (stop_pend) begin
            eng_req <= 1'b1;
            eng_op  <= OP_STOP;
            state   <= S_STOP_W;
          end else begin
            state <= S_OWNED;
          end
        end
        S_DATA_W: if (eng_done) begin
          if (eng_nack) begin
            tx_err <= 1'b1;
            state  <= S_FLUSH;
          end else if (stop_pend) begin
            eng_req <= 1'b1;
            eng_op  <= OP_STOP;
            state   <= S_STOP_W;
          end else begin
            state <= S_OWNED;
          end
        end
        S_FLUSH: if (!has || head[START_BIT]) begin
          eng_req <= 1'b1;
          eng_op  <= OP_STOP;
          state   <= S_STOP_W;
        end
        S_STOP_W: if (eng_done) begin
          bus_busy <= 1'b0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq #(
  parameter int DEPTH  = 16,
  parameter int BYTE_W = 8,
  localparam int WORD_W = BYTE_W + 2,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_push,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              rx_pop,
  output logic [BYTE_W-1:0] rx_data,
  output logic              eng_req,
  output logic [2:0]        eng_op,
  output logic [BYTE_W-1:0] eng_wdata,
  output logic              eng_mnack,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic [BYTE_W-1:0] eng_rdata,
  output logic              tx_empty,
  output logic              tx_full,
  output logic              tx_half,
  output logic              rx_empty,
  output logic              rx_full,
  output logic              bus_busy,
  output logic              tx_err
);
  localparam logic [AW:0] FULL_L = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_L = (AW+1)'(DEPTH / 2);

  logic [WORD_W-1:0] tx_head;
  logic [AW:0]       tx_lvl, rx_lvl;
  logic              tx_pop, rx_push;

  cmdq_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .wdata(tx_word),
    .pop(tx_pop), .rdata(tx_head), .level(tx_lvl)
  );

  cmdq_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .wdata(eng_rdata),
    .pop(rx_pop), .rdata(rx_data), .level(rx_lvl)
  );

  assign tx_empty = (tx_lvl == '0);
  assign tx_full  = (tx_lvl == FULL_L);
  assign tx_half  = (tx_lvl <= HALF_L);
  assign rx_empty = (rx_lvl == '0);
  assign rx_full  = (rx_lvl == FULL_L);

  cmd_seq_fsm #(.BYTE_W(BYTE_W)) u_fsm (
    .clk(clk), .rst(rst), .head(tx_head), .tx_empty(tx_empty),
    .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
    .eng_mnack(eng_mnack), .eng_done(eng_done), .eng_nack(eng_nack),
    .bus_busy(bus_busy), .tx_err(tx_err)
  );
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       eng_req,
  input logic [2:0] eng_op,
  input logic       eng_done,
  input logic       bus_busy,
  input logic       tx_err,
  input logic       rx_full
);
  logic       outst;
  logic [2:0] last_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      outst   <= 1'b0;
      last_op <= 3'd4;
    end else begin
      if (eng_req) begin
        outst   <= 1'b1;
        last_op <= eng_op;
      end else if (eng_done) begin
        outst <= 1'b0;
      end
    end
  end

  // R10
  one_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    eng_req |-> !outst);

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_busy) |-> ($past(eng_done) && last_op == 3'd0));

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_busy) |-> ($past(eng_done) && last_op == 3'd4));

  // R5
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_err |=> !tx_err);

  // R9
  rx_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_op == 3'd3) |-> !rx_full);
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk u_chk (
  .clk(clk), .rst(rst), .eng_req(eng_req), .eng_op(eng_op),
  .eng_done(eng_done), .bus_busy(bus_busy), .tx_err(tx_err),
  .rx_full(rx_full)
);

// File: tb/tb_i2c_cmd_seq.sv
`timescale 1ns/1ps
module tb_i2c_cmd_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_push = 1'b0;
  logic [9:0] tx_word = '0;
  logic rx_pop = 1'b0;
  logic [7:0] rx_data, eng_wdata, eng_rdata;
  logic eng_req, eng_mnack, eng_done, eng_nack;
  logic [2:0] eng_op;
  logic tx_empty, tx_full, tx_half, rx_empty, rx_full, bus_busy, tx_err;

  always #4 clk = ~clk;

  i2c_cmd_seq dut (.*);

  // stimulus words: bit9 stop, bit8 start, bits 7:0 byte
  localparam logic [9:0] STIM [19] = '{
    10'h1A0, 10'h011, 10'h222, 10'h3A0, 10'h1A1, 10'h203,
    10'h1A0, 10'h055, 10'h1A1, 10'h201, 10'h1A1, 10'h200,
    10'h1A0, 10'h0EE, 10'h077, 10'h088, 10'h3A0, 10'h099, 10'h3A0};
  // expected engine log: {op[2:0], byte[7:0], master_nack}
  localparam logic [11:0] EXP [34] = '{
    12'h000, 12'h540, 12'h422, 12'h444, 12'h800,
    12'h000, 12'h540, 12'h800,
    12'h000, 12'h542, 12'h660, 12'h662, 12'h665, 12'h800,
    12'h000, 12'h540, 12'h4AA, 12'h200, 12'h542, 12'h667, 12'h800,
    12'h000, 12'h542, 12'h800,
    12'h000, 12'h540, 12'h5DC, 12'h800, 12'h000, 12'h540, 12'h800,
    12'h000, 12'h540, 12'h800};

  int checks = 0, fails = 0, nlog = 0, overlap = 0, nerr = 0, cyc = 0;
  logic [11:0] lg [0:127];
  logic [7:0] rd_idx = 8'h30;
  logic hold_wr = 1'b0;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] w, input bit force_it);
    @(posedge clk); #1;
    while (tx_full && !force_it) begin @(posedge clk); #1; end
    tx_push = 1'b1; tx_word = w;
    @(posedge clk); #1;
    tx_push = 1'b0;
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string what);
    chk(rx_data == exp, what, rx_data, exp);
    rx_pop = 1'b1;
    @(posedge clk); #1;
    rx_pop = 1'b0;
  endtask

  task automatic wait_log(input int n);
    while (nlog < n) begin @(posedge clk); #1; end
    repeat (30) @(posedge clk);
    #1;
  endtask

  // engine model: 3-cycle latency, NACKs the byte 0xEE
  initial begin
    eng_done = 1'b0; eng_nack = 1'b0; eng_rdata = '0;
    forever begin
      @(posedge clk); #1;
      while (eng_req) begin
        automatic logic [2:0] o = eng_op;
        automatic logic [7:0] d = eng_wdata;
        automatic logic m = eng_mnack;
        if (o == 3'd3) begin
          lg[nlog] = {o, rd_idx, m};
          eng_rdata = rd_idx;
          rd_idx++;
        end else if (o == 3'd2) begin
          lg[nlog] = {o, d, 1'b0};
        end else begin
          lg[nlog] = {o, 8'h00, 1'b0};
        end
        nlog++;
        eng_nack = (o == 3'd2) && (d == 8'hEE);
        repeat (2) begin @(posedge clk); #1; if (eng_req) overlap++; end
        while (hold_wr && o == 3'd2) begin @(posedge clk); #1; if (eng_req) overlap++; end
        eng_done = 1'b1;
        @(posedge clk); #1;
        eng_done = 1'b0; eng_nack = 1'b0;
      end
    end
  end

  initial forever begin
    @(posedge clk); #1;
    if (tx_err) nerr++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      summary();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R11 reset state
    chk(tx_empty == 1'b1, "R11 tx_empty", tx_empty, 1);
    chk(tx_full == 1'b0, "R11 tx_full", tx_full, 0);
    chk(rx_empty == 1'b1, "R11 rx_empty", rx_empty, 1);
    chk(bus_busy == 1'b0, "R11 bus_busy", bus_busy, 0);
    chk(eng_req == 1'b0 && tx_err == 1'b0, "R11 req/err idle", eng_req, 0);

    foreach (STIM[i]) push(STIM[i], 1'b0);
    wait_log(34);
    chk(nlog == 34, "R1 R5 R6 log length", nlog, 34);
    for (int i = 0; i < 34; i++)
      chk(lg[i] == EXP[i], $sformatf("R1 R2 R3 R4 R5 R6 engine op %0d", i), lg[i], EXP[i]);
    chk(nerr == 1, "R5 tx_err pulses", nerr, 1);
    for (int i = 0; i < 4; i++) pop_chk(8'h30 + 8'(i), "R9 rx order");
    chk(rx_empty == 1'b1, "R9 rx_empty after drain", rx_empty, 1);

    // R8 queue full, R7 busy while owned
    hold_wr = 1'b1;
    push(10'h1A0, 1'b0);
    repeat (12) @(posedge clk);
    #1;
    chk(bus_busy == 1'b1, "R7 busy after start", bus_busy, 1);
    for (int k = 1; k < 16; k++) push(10'(k), 1'b0);
    push(10'h2FF, 1'b0);
    chk(tx_full == 1'b1, "R8 tx_full", tx_full, 1);
    chk(tx_half == 1'b0, "R8 tx_half when full", tx_half, 0);
    push(10'h0CC, 1'b1);
    hold_wr = 1'b0;
    wait_log(53);
    chk(nlog == 53, "R8 push while full ignored", nlog, 53);
    chk(lg[51] == 12'h5FE, "R2 last data byte", lg[51], 12'h5FE);
    chk(lg[52] == 12'h800, "R2 stop after data", lg[52], 12'h800);
    chk(tx_empty == 1'b1 && tx_half == 1'b1, "R8 tx_empty", tx_empty, 1);
    chk(bus_busy == 1'b0, "R7 busy cleared by stop", bus_busy, 0);

    // R9 receive queue full stalls reads
    push(10'h1A1, 1'b0);
    push(10'h211, 1'b0);
    wait_log(71);
    chk(rx_full == 1'b1, "R9 rx_full", rx_full, 1);
    chk(nlog == 71, "R9 read stalled while full", nlog, 71);
    for (int i = 0; i < 17; i++) begin
      pop_chk(8'h34 + 8'(i), "R9 rx order after stall");
      repeat (8) @(posedge clk);
      #1;
    end
    chk(lg[71] == 12'h689, "R3 last read master NACK", lg[71], 12'h689);
    chk(lg[72] == 12'h800, "R3 stop after read", lg[72], 12'h800);
    chk(rx_empty == 1'b1, "R9 rx_empty end", rx_empty, 1);
    chk(overlap == 0, "R10 request while busy", overlap, 0);
    summary();
  end
endmodule